// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the control unit of a small microcoded processor. It holds a 6-bit microprogram counter and a read-only microcode store built as logic. Each microword carries 17 datapath control lines and a 3-bit jump-type code. The jump-type code chooses the next microaddress. It can advance by one, hold while memory is busy, return to the fetch entry, dispatch on the opcode group, or branch back to fetch depending on the zero flag.

The datapath sits outside the block. Its opcode register feeds the 6-bit opcode input, and its comparator and memory feed the zero and busy inputs. The block drives the control lines from the current microword and shows the current microaddress. The stored microprogram covers these routines: a four-step fetch, register and immediate ALU operations, load, store, branch-if-zero, branch-if-nonzero, jump, jump-register, jump-and-link and jump-and-link-register.

Top module: `ucode_sequencer`

## Requirements
- R1: A low `rst_n` sampled at a rising edge sets `uaddr` to 0, the fetch entry, from the following cycle on. Reset takes priority over every jump type.
- R2: The fetch routine occupies addresses 0..3. Address 0 steps to 1, and address 2 steps to 3, regardless of `busy`, `zero` or `opcode`.
- R3: At a spin step (addresses 1, 13 and 18), `uaddr` holds while `busy` is 1 and advances by one in the first cycle `busy` is 0.
- R4: The last step of every routine returns to address 0 in the next cycle: address 6 (ALU), 9 (ALU immediate), 14 (load), 19 (store), 24, 29, 31, 33, 37 and 41.
- R5: Address 3 dispatches on `opcode`. Opcode 0x00 goes to 4. Opcodes 0x08..0x0F go to 7. Opcode 0x23 goes to 10 and 0x2B goes to 15. Opcode 0x04 (branch if zero) goes to 20 and 0x05 (branch if nonzero) goes to 25. Opcode 0x02 goes to 30, 0x06 goes to 32, 0x03 goes to 34 and 0x07 goes to 38.
- R6: Every other opcode value dispatches to address 0.
- R7: At address 21 (branch-if-zero test), `zero`=1 steps to 22 and `zero`=0 returns to 0.
- R8: At address 26 (branch-if-nonzero test), `zero`=1 returns to 0 and `zero`=0 steps to 27.
- R9: The `ctrl` fields are laid out as follows. Bit 16 loads IR. Bits 15:14 select the ALU operation (0 func, 1 A+4, 2 A+B, 3 pass A). Bit 13 loads A, bit 12 loads B and bit 11 loads MA. Bits 10:8 select the register (0 rs, 1 rt, 2 rd, 3 PC, 4 link register 31). Bit 7 writes the register and bit 6 drives the register onto the bus. Bits 5:4 select the immediate form (0 sign-extend, 1 zero-extend, 2 sign-extend shifted left 2, 3 jump target). Bit 3 drives the immediate onto the bus and bit 2 drives the ALU onto the bus. Bit 1 selects a memory write and bit 0 enables memory. The fetch words are MA←PC, IR←memory, A←PC and PC←A+4.
- R10: In each routine, the steps between the entry and the exit, other than spin and test steps, advance by one.
- R11: Jump-and-link writes the link register from A at address 35 (`ctrl`=0xC484). Store writes memory from rt at address 18 (`ctrl`=0x0143). The branch-if-zero routine loads B with the shifted immediate at address 23 (`ctrl`=0x1028).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode of the current macroinstruction |
| zero | input | 1 | Zero flag from the datapath |
| busy | input | 1 | Memory busy flag |
| ctrl | output | 17 | Datapath control lines of the current microword |
| uaddr | output | 6 | Current microprogram address |

## Verification
`uaddr` is registered, and `ctrl` is decoded from it through logic alone. So `ctrl` reflects the current address in the same cycle, and a new `uaddr` value appears one rising edge after the inputs that select it. The bench changes inputs 1 ns after an edge. It checks `uaddr` and `ctrl` at that same point, once per edge, against an address predicted from the inputs held during the cycle just ended. It sweeps all 64 opcodes twice, once with `zero` low and once high, with busy-hold lengths that vary with the opcode. It then applies a reset in the middle of a routine.

// File: rtl/ucode_pkg.sv
// Shared definitions for the microprogram sequencer: widths, jump-type
// codes, the control-word layout and the routine entry addresses.
// Assumes a 6-bit microaddress is enough to hold every routine.
package ucode_pkg;

    localparam int OP_W   = 6;
    localparam int UA_W   = 6;
    localparam int CTRL_W = 17;

    // Next-address selector carried by every microword
    typedef enum logic [2:0] {
        JT_NEXT     = 3'd0,
        JT_SPIN     = 3'd1,
        JT_FETCH    = 3'd2,
        JT_DISPATCH = 3'd3,
        JT_FEQZ     = 3'd4,
        JT_FNEZ     = 3'd5
    } jtype_e;

    // ALU operation select
    localparam logic [1:0] OP_FUNC = 2'd0;
    localparam logic [1:0] OP_ADD4 = 2'd1;
    localparam logic [1:0] OP_ADD  = 2'd2;
    localparam logic [1:0] OP_PASS = 2'd3;

    // Register select
    localparam logic [2:0] RS_RS   = 3'd0;
    localparam logic [2:0] RS_RT   = 3'd1;
    localparam logic [2:0] RS_RD   = 3'd2;
    localparam logic [2:0] RS_PC   = 3'd3;
    localparam logic [2:0] RS_LINK = 3'd4;

    // Immediate form select
    localparam logic [1:0] IX_SEXT = 2'd0;
    localparam logic [1:0] IX_UEXT = 2'd1;
    localparam logic [1:0] IX_SHL2 = 2'd2;
    localparam logic [1:0] IX_JTGT = 2'd3;

    // 17 datapath control lines, MSB first
    typedef struct packed {
        logic       ld_ir;
        logic [1:0] op_sel;
        logic       ld_a;
        logic       ld_b;
        logic       ld_ma;
        logic [2:0] reg_sel;
        logic       reg_wr;
        logic       en_reg;
        logic [1:0] ext_sel;
        logic       en_imm;
        logic       en_alu;
        logic       mem_wr;
        logic       en_mem;
    } ctrl_t;

    typedef struct packed {
        jtype_e jt;
        ctrl_t  ctl;
    } uword_t;

    // Routine entry addresses in the microcode store
    localparam int EA_FETCH = 0;
    localparam int EA_ALU   = 4;
    localparam int EA_ALUI  = 7;
    localparam int EA_LW    = 10;
    localparam int EA_SW    = 15;
    localparam int EA_BEQZ  = 20;
    localparam int EA_BNEZ  = 25;
    localparam int EA_J     = 30;
    localparam int EA_JR    = 32;
    localparam int EA_JAL   = 34;
    localparam int EA_JALR  = 38;
    localparam int EA_LAST  = 41;

endpackage

// File: rtl/ucode_dispatch.sv
// Opcode-group dispatch table: maps an opcode to the entry address of
// its microroutine. Unknown opcodes map to the fetch entry.
// Assumes OP_W is 6 (the patterns below are 6-bit).
module ucode_dispatch
    import ucode_pkg::*;
#(
    parameter int OPW = OP_W,
    parameter int UAW = UA_W
) (
    input  logic [OPW-1:0] opcode,
    output logic [UAW-1:0] entry
);

    // Select the routine entry for the opcode group
    always_comb begin
        casez (opcode)
            6'b000000: entry = UAW'(EA_ALU);
            6'b001???: entry = UAW'(EA_ALUI);
            6'b100011: entry = UAW'(EA_LW);
            6'b101011: entry = UAW'(EA_SW);
            6'b000100: entry = UAW'(EA_BEQZ);
            6'b000101: entry = UAW'(EA_BNEZ);
            6'b000010: entry = UAW'(EA_J);
            6'b000110: entry = UAW'(EA_JR);
            6'b000011: entry = UAW'(EA_JAL);
            6'b000111: entry = UAW'(EA_JALR);
            default:   entry = UAW'(EA_FETCH);
        endcase
    end

endmodule

// File: rtl/ucode_rom.sv
// Microcode store, built as combinational logic. Each word carries a
// jump type and 17 control lines. Addresses past the last routine hold
// an empty word that returns to fetch.
module ucode_rom
    import ucode_pkg::*;
#(
    parameter int UAW = UA_W
) (
    input  logic [UAW-1:0] addr,
    output uword_t         word
);

    function automatic ctrl_t rd2a(input logic [2:0] s);
        ctrl_t c = '0;
        c.reg_sel = s; c.en_reg = 1'b1; c.ld_a = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t rd2b(input logic [2:0] s);
        ctrl_t c = '0;
        c.reg_sel = s; c.en_reg = 1'b1; c.ld_b = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t rd2ma(input logic [2:0] s);
        ctrl_t c = '0;
        c.reg_sel = s; c.en_reg = 1'b1; c.ld_ma = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t imm2b(input logic [1:0] x);
        ctrl_t c = '0;
        c.ext_sel = x; c.en_imm = 1'b1; c.ld_b = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t imm2a(input logic [1:0] x);
        ctrl_t c = '0;
        c.ext_sel = x; c.en_imm = 1'b1; c.ld_a = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t alu2r(input logic [1:0] op, input logic [2:0] s);
        ctrl_t c = '0;
        c.op_sel = op; c.en_alu = 1'b1; c.reg_sel = s; c.reg_wr = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t alu2ma(input logic [1:0] op);
        ctrl_t c = '0;
        c.op_sel = op; c.en_alu = 1'b1; c.ld_ma = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t mem2ir();
        ctrl_t c = '0;
        c.en_mem = 1'b1; c.ld_ir = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t mem2r(input logic [2:0] s);
        ctrl_t c = '0;
        c.en_mem = 1'b1; c.reg_sel = s; c.reg_wr = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t r2mem(input logic [2:0] s);
        ctrl_t c = '0;
        c.reg_sel = s; c.en_reg = 1'b1; c.mem_wr = 1'b1; c.en_mem = 1'b1;
        return c;
    endfunction

    function automatic uword_t uw(input jtype_e j, input ctrl_t c);
        uword_t w;
        w.jt = j; w.ctl = c;
        return w;
    endfunction

    // Decode the microaddress into its microword
    always_comb begin
        case (int'(addr))
            // fetch
            0:  word = uw(JT_NEXT,     rd2ma(RS_PC));
            1:  word = uw(JT_SPIN,     mem2ir());
            2:  word = uw(JT_NEXT,     rd2a(RS_PC));
            3:  word = uw(JT_DISPATCH, alu2r(OP_ADD4, RS_PC));
            // register ALU
            4:  word = uw(JT_NEXT,     rd2a(RS_RS));
            5:  word = uw(JT_NEXT,     rd2b(RS_RT));
            6:  word = uw(JT_FETCH,    alu2r(OP_FUNC, RS_RD));
            // immediate ALU
            7:  word = uw(JT_NEXT,     rd2a(RS_RS));
            8:  word = uw(JT_NEXT,     imm2b(IX_SEXT));
            9:  word = uw(JT_FETCH,    alu2r(OP_FUNC, RS_RT));
            // load
            10: word = uw(JT_NEXT,     rd2a(RS_RS));
            11: word = uw(JT_NEXT,     imm2b(IX_SEXT));
            12: word = uw(JT_NEXT,     alu2ma(OP_ADD));
            13: word = uw(JT_SPIN,     mem2r(RS_RT));
            14: word = uw(JT_FETCH,    '0);
            // store
            15: word = uw(JT_NEXT,     rd2a(RS_RS));
            16: word = uw(JT_NEXT,     imm2b(IX_SEXT));
            17: word = uw(JT_NEXT,     alu2ma(OP_ADD));
            18: word = uw(JT_SPIN,     r2mem(RS_RT));
            19: word = uw(JT_FETCH,    '0);
            // branch if zero
            20: word = uw(JT_NEXT,     rd2a(RS_RS));
            21: word = uw(JT_FNEZ,     '0);
            22: word = uw(JT_NEXT,     rd2a(RS_PC));
            23: word = uw(JT_NEXT,     imm2b(IX_SHL2));
            24: word = uw(JT_FETCH,    alu2r(OP_ADD, RS_PC));
            // branch if nonzero
            25: word = uw(JT_NEXT,     rd2a(RS_RS));
            26: word = uw(JT_FEQZ,     '0);
            27: word = uw(JT_NEXT,     rd2a(RS_PC));
            28: word = uw(JT_NEXT,     imm2b(IX_SHL2));
            29: word = uw(JT_FETCH,    alu2r(OP_ADD, RS_PC));
            // jump
            30: word = uw(JT_NEXT,     imm2a(IX_JTGT));
            31: word = uw(JT_FETCH,    alu2r(OP_PASS, RS_PC));
            // jump register
            32: word = uw(JT_NEXT,     rd2a(RS_RS));
            33: word = uw(JT_FETCH,    alu2r(OP_PASS, RS_PC));
            // jump and link
            34: word = uw(JT_NEXT,     rd2a(RS_PC));
            35: word = uw(JT_NEXT,     alu2r(OP_PASS, RS_LINK));
            36: word = uw(JT_NEXT,     imm2a(IX_JTGT));
            37: word = uw(JT_FETCH,    alu2r(OP_PASS, RS_PC));
            // jump and link register
            38: word = uw(JT_NEXT,     rd2a(RS_PC));
            39: word = uw(JT_NEXT,     alu2r(OP_PASS, RS_LINK));
            40: word = uw(JT_NEXT,     rd2a(RS_RS));
            41: word = uw(JT_FETCH,    alu2r(OP_PASS, RS_PC));
            default: word = uw(JT_FETCH, '0);
        endcase
    end

endmodule

// File: rtl/ucode_next.sv
// Next-address logic: picks the following microaddress from the jump
// type, the current address, the dispatch entry and the zero and busy
// flags. Unused jump-type codes behave as a return to fetch.
module ucode_next
    import ucode_pkg::*;
#(
    parameter int UAW = UA_W
) (
    input  jtype_e         jt,
    input  logic [UAW-1:0] upc,
    input  logic [UAW-1:0] entry,
    input  logic           zero,
    input  logic           busy,
    output logic [UAW-1:0] nxt
);

    localparam logic [UAW-1:0] FETCH_A = UAW'(EA_FETCH);

    logic [UAW-1:0] inc;

    // Sequential successor of the current address
    always_comb inc = upc + UAW'(1);

    // Select the next address by jump type
    always_comb begin
        case (jt)
            JT_NEXT:     nxt = inc;
            JT_SPIN:     nxt = busy ? upc : inc;
            JT_FETCH:    nxt = FETCH_A;
            JT_DISPATCH: nxt = entry;
            JT_FEQZ:     nxt = zero ? FETCH_A : inc;
            JT_FNEZ:     nxt = zero ? inc : FETCH_A;
            default:     nxt = FETCH_A;
        endcase
    end

endmodule

// File: rtl/ucode_sequencer.sv
// Microprogram sequencer top: the microprogram counter register, the
// microcode store, the dispatch table and the next-address logic.
// Assumes a synchronous active-low reset; ctrl is combinational from
// the registered microaddress.
module ucode_sequencer
    import ucode_pkg::*;
#(
    parameter int OPW = OP_W,
    parameter int UAW = UA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPW-1:0]    opcode,
    input  logic              zero,
    input  logic              busy,
    output logic [CTRL_W-1:0] ctrl,
    output logic [UAW-1:0]    uaddr
);

    localparam logic [UAW-1:0] FETCH_A = UAW'(EA_FETCH);

    logic [UAW-1:0] upc;
    logic [UAW-1:0] upc_nxt;
    logic [UAW-1:0] entry;
    uword_t         word;

    ucode_rom #(.UAW(UAW)) u_rom (
        .addr (upc),
        .word (word)
    );

    ucode_dispatch #(.OPW(OPW), .UAW(UAW)) u_disp (
        .opcode (opcode),
        .entry  (entry)
    );

    ucode_next #(.UAW(UAW)) u_next (
        .jt    (word.jt),
        .upc   (upc),
        .entry (entry),
        .zero  (zero),
        .busy  (busy),
        .nxt   (upc_nxt)
    );

    // Microprogram counter register
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= FETCH_A;
        else        upc <= upc_nxt;
    end

    // Drive outputs from the current microword
    always_comb begin
        ctrl  = word.ctl;
        uaddr = upc;
    end

endmodule

// File: rtl/ucode_sequencer_chk.sv
// Property checker for the microprogram sequencer, bound to the top.
// Assumes the fixed routine layout of the default microcode store.
module ucode_sequencer_chk #(
    parameter int OPW = 6,
    parameter int UAW = 6,
    parameter int CW  = 17
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] opcode,
    input logic           zero,
    input logic           busy,
    input logic [CW-1:0]  ctrl,
    input logic [UAW-1:0] uaddr
);

    // R1
    reset_entry_chk: assert property (@(posedge clk)
        !rst_n |=> uaddr == UAW'(0));

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UAW'(0) |=> uaddr == UAW'(1));

    // R3
    spin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UAW'(1) && busy) |=> uaddr == UAW'(1));

    // R3
    spin_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UAW'(1) && !busy) |=> uaddr == UAW'(2));

    // R4
    alu_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UAW'(6) |=> uaddr == UAW'(0));

    // R5
    dispatch_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UAW'(3) && opcode == OPW'(0)) |=> uaddr == UAW'(4));

    // R7
    beqz_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UAW'(21) |=> uaddr == (zero ? UAW'(22) : UAW'(0)));

    // R8
    bnez_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UAW'(26) |=> uaddr == (zero ? UAW'(0) : UAW'(27)));

    // R9
    fetch_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uaddr == UAW'(1) |-> (ctrl[16] && ctrl[0] && !ctrl[1]));

endmodule

bind ucode_sequencer ucode_sequencer_chk #(
    .OPW(OPW), .UAW(UAW), .CW(ucode_pkg::CTRL_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .zero   (zero),
    .busy   (busy),
    .ctrl   (ctrl),
    .uaddr  (uaddr)
);

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic        zero = 1'b0;
    logic        busy = 1'b0;
    logic [16:0] ctrl;
    logic [5:0]  uaddr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    ucode_sequencer uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
        .busy(busy), .ctrl(ctrl), .uaddr(uaddr)
    );

    always #2.5 clk = ~clk;

    // Control word from its fields, positions per R9
    function automatic logic [16:0] cw(input int ldir, input int op, input int lda,
                                       input int ldb, input int ldma, input int rsel,
                                       input int rwr, input int enr, input int ext,
                                       input int enimm, input int enalu,
                                       input int mwr, input int enm);
        return 17'((ldir << 16) | (op << 14) | (lda << 13) | (ldb << 12) | (ldma << 11) |
                   (rsel << 8) | (rwr << 7) | (enr << 6) | (ext << 4) | (enimm << 3) |
                   (enalu << 2) | (mwr << 1) | enm);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock; sample 1 ns after the edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Dispatch entry per R5 and R6
    function automatic int entry_of(input int op);
        if (op == 0) return 4;
        if (op >= 8 && op <= 15) return 7;
        case (op)
            'h23: return 10;
            'h2B: return 15;
            'h04: return 20;
            'h05: return 25;
            'h02: return 30;
            'h06: return 32;
            'h03: return 34;
            'h07: return 38;
            default: return 0;
        endcase
    endfunction

    // Run fetch then the routine for one opcode with a fixed zero flag
    task automatic run_op(input int op, input bit z);
        int e, len, sp, bp, i;
        bit fin, is_fnez, leave;
        zero = z;
        check("R2 fetch0 addr", uaddr, 0);
        check("R9 fetch0 word", ctrl, cw(0,0,0,0,1,3,0,1,0,0,0,0,0));
        tick();
        check("R2 fetch1 addr", uaddr, 1);
        check("R9 fetch1 word", ctrl, cw(1,0,0,0,0,0,0,0,0,0,0,0,1));
        for (int k = 0; k < op % 3; k++) begin
            busy = 1'b1;
            tick();
            check("R3 fetch spin hold", uaddr, 1);
        end
        busy = 1'b0;
        tick();
        check("R3 fetch spin release", uaddr, 2);
        check("R9 fetch2 word", ctrl, cw(0,0,1,0,0,3,0,1,0,0,0,0,0));
        tick();
        check("R2 fetch3 addr", uaddr, 3);
        check("R9 fetch3 word", ctrl, cw(0,1,0,0,0,3,1,0,0,0,1,0,0));
        opcode = 6'(op);
        tick();
        e = entry_of(op);
        check(e == 0 ? "R6 unknown opcode dispatch" : "R5 opcode dispatch", uaddr, e);
        opcode = 6'(~op);
        if (e == 0) return;
        sp = -1; bp = -1; is_fnez = 1'b0;
        case (e)
            4, 7:   len = 3;
            10, 15: begin len = 5; sp = 3; end
            20:     begin len = 5; bp = 1; is_fnez = 1'b1; end
            25:     begin len = 5; bp = 1; end
            30, 32: len = 2;
            default: len = 4;
        endcase
        i = 0;
        fin = 1'b0;
        while (!fin) begin
            if (e + i == 35) check("R11 link write word", ctrl, 'hC484);
            if (e + i == 18) check("R11 store word", ctrl, 'h0143);
            if (e + i == 23) check("R11 branch offset word", ctrl, 'h1028);
            if (i == sp) begin
                busy = 1'b1;
                tick();
                check("R3 routine spin hold", uaddr, e + i);
                busy = 1'b0;
            end
            if (i == bp) begin
                leave = is_fnez ? !z : z;
                tick();
                if (leave) begin
                    check(is_fnez ? "R7 beqz not-taken" : "R8 bnez not-taken", uaddr, 0);
                    fin = 1'b1;
                end else begin
                    check(is_fnez ? "R7 beqz taken" : "R8 bnez taken", uaddr, e + i + 1);
                    i++;
                end
            end else if (i == len - 1) begin
                tick();
                check("R4 routine exit", uaddr, 0);
                fin = 1'b1;
            end else begin
                tick();
                check("R10 routine step", uaddr, e + i + 1);
                i++;
            end
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) tick();
        check("R1 reset addr", uaddr, 0);
        check("R1 reset word", ctrl, cw(0,0,0,0,1,3,0,1,0,0,0,0,0));
        rst_n = 1'b1;
        for (int zz = 0; zz < 2; zz++)
            for (int op = 0; op < 64; op++)
                run_op(op, zz[0]);
        // mid-routine reset while the load spin step is waiting
        opcode = 6'h23;
        busy = 1'b0;
        repeat (4) tick();
        check("R5 load entry", uaddr, 10);
        repeat (3) tick();
        busy = 1'b1;
        tick();
        check("R3 load spin hold", uaddr, 13);
        rst_n = 1'b0;
        tick();
        check("R1 reset over spin", uaddr, 0);
        rst_n = 1'b1;
        busy = 1'b0;
        tick();
        check("R1 restart from fetch", uaddr, 1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule